// File: doc/BRIEF.md
# Linear CCD Clock Timing Generator

This block drives the digital clock pins of a three-colour linear image sensor from one fast system clock (100 MHz in the intended system). It produces a complementary pair of transfer clocks, a per-pixel reset pulse, a per-pixel clamp pulse and one readout-gate pulse for each colour channel. It also gives downstream sampling logic a one-cycle line-start strobe and a one-cycle pixel-valid strobe. Every pulse width and offset is a configuration input counted in system-clock ticks. The sequencer has four phases. The lead holds the transfer clocks still before the gates rise. The gate phase drives the readout gates high. The guard holds the clocks still after the gates fall. The run phase clocks out a parameterised number of pixels.

While the enable input is high, lines follow one another with no gap other than the configured lead. When enable is low at the end of a line, the block parks in idle. In idle the transfer clocks sit in the state that a readout-gate pulse needs, so the next line can begin without a glitch. At 1 MHz pixel rate the package constants give typical settings: 100 ticks per pixel, a 5-tick reset, a 10-tick clamp, a 10-tick lead, a 500-tick gate and a 200-tick guard. The line-length parameter defaults to 10755 pixels, which is the minimum transfer count the sensor needs between gate pulses.

Top module: `ccd_line_timing`

## Requirements
- R1: During and after reset, with enable low, xfer_p1 is 1 and xfer_p2 is 0. rst_pulse, clamp_pulse, every bit of gate_o, line_start and pix_valid are 0.
- R2: The first line_start after enable rises appears cfg_lead+1 cycles after the clock edge that samples enable high. All bits of gate_o are high together for exactly cfg_gate_width cycles. line_start is high only in the first of those cycles.
- R3: From the start of the lead to the end of the guard, xfer_p1 stays 1 and rst_pulse and clamp_pulse stay 0. The first transfer toggle (xfer_p1 falling) comes exactly cfg_guard cycles after the last gate-high cycle.
- R4: In the run phase each pixel lasts cfg_pix_div cycles. Number the ticks t = 0 to cfg_pix_div-1. xfer_p1 is 0 for t < cfg_pix_div/2 (integer division) and 1 for the other ticks. xfer_p2 is always the inverse of xfer_p1.
- R5: rst_pulse is high in run ticks with cfg_rs_start <= t < cfg_rs_start+cfg_rs_width, and low at all other times.
- R6: clamp_pulse is high in run ticks with cfg_clp_start <= t < cfg_clp_start+cfg_clp_width, and low at all other times. It is placed after the reset pulse and never overlaps it.
- R7: pix_valid is high for one cycle at tick t = cfg_pix_div-1 of each pixel. That gives exactly LINE_PIX pulses per line, and none outside the run phase.
- R8: With enable held high, consecutive line_start pulses are exactly cfg_gate_width + cfg_guard + LINE_PIX*cfg_pix_div + cfg_lead cycles apart.
- R9: Lowering enable during a line does not shorten that line. If enable is low when the line ends, no further line_start follows, and the outputs return to the idle state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run lines while high; sampled in idle and at each line end |
| cfg_pix_div | input | CNT_W | System-clock ticks per pixel (>= 2) |
| cfg_rs_start | input | CNT_W | Reset pulse start tick within a pixel |
| cfg_rs_width | input | CNT_W | Reset pulse width in ticks |
| cfg_clp_start | input | CNT_W | Clamp pulse start tick (>= reset end) |
| cfg_clp_width | input | CNT_W | Clamp pulse width in ticks |
| cfg_lead | input | CNT_W | Ticks of parked clocks before the gates rise (>= 1) |
| cfg_gate_width | input | CNT_W | Readout-gate high time in ticks (>= 1) |
| cfg_guard | input | CNT_W | Ticks of parked clocks after the gates fall (>= 1) |
| xfer_p1 | output | 1 | Transfer clock phase 1 |
| xfer_p2 | output | 1 | Transfer clock phase 2 (inverse of phase 1) |
| rst_pulse | output | 1 | Per-pixel reset pulse |
| clamp_pulse | output | 1 | Per-pixel clamp pulse |
| gate_o | output | N_GATE | Readout-gate pulses, one per colour |
| line_start | output | 1 | One-cycle strobe on the first gate cycle |
| pix_valid | output | 1 | One-cycle strobe on the last tick of each pixel |

## Verification
All outputs pass through one register stage. The output state changes one cycle after the sequencer state changes, so the first line_start appears cfg_lead+2 rising edges after enable is driven, counting the edge that samples it. The bench measures that edge count and then uses the first line_start as cycle zero. From there it predicts every output for every cycle of two whole lines: it takes the offset modulo the line period and decodes gate, guard, run tick and lead arithmetically. It samples all outputs on the falling edge, half a cycle after the edge that set them. It sweeps five timing configurations, including the typical one, and observes a further full line period after enable drops to confirm the return to idle.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LEAD  = 3'd1,
      ST_GATE  = 3'd2,
      ST_GUARD = 3'd3,
      ST_RUN   = 3'd4
   } tg_state_e;

   // typical settings at a 100 MHz system clock and 1 MHz pixel rate
   localparam int DEF_PIX_DIV   = 100;
   localparam int DEF_RS_START  = 0;
   localparam int DEF_RS_WIDTH  = 5;
   localparam int DEF_CLP_START = 10;
   localparam int DEF_CLP_WIDTH = 10;
   localparam int DEF_LEAD      = 10;
   localparam int DEF_GATE      = 500;
   localparam int DEF_GUARD     = 200;
endpackage

// File: rtl/ccd_tg_seq.sv
module ccd_tg_seq
   import ccd_tg_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int LINE_PIX = 10755
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [CNT_W-1:0] cfg_pix_div,
   input  logic [CNT_W-1:0] cfg_lead,
   input  logic [CNT_W-1:0] cfg_gate_width,
   input  logic [CNT_W-1:0] cfg_guard,
   output tg_state_e        state,
   output logic [CNT_W-1:0] tick
);
   localparam int PIX_W = (LINE_PIX > 1) ? $clog2(LINE_PIX) : 1;
   localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(LINE_PIX - 1);

   logic [CNT_W-1:0] limit;
   logic [PIX_W-1:0] pix;
   logic             done;

   always_comb begin
      case (state)
         ST_LEAD:  limit = cfg_lead;
         ST_GATE:  limit = cfg_gate_width;
         ST_GUARD: limit = cfg_guard;
         ST_RUN:   limit = cfg_pix_div;
         default:  limit = CNT_W'(1);
      endcase
   end

   assign done = (tick == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         tick  <= '0;
         pix   <= '0;
      end else if (state == ST_IDLE) begin
         tick <= '0;
         pix  <= '0;
         if (enable) state <= ST_LEAD;
      end else if (done) begin
         tick <= '0;
         case (state)
            ST_LEAD:  state <= ST_GATE;
            ST_GATE:  state <= ST_GUARD;
            ST_GUARD: begin
               state <= ST_RUN;
               pix   <= '0;
            end
            ST_RUN: begin
               if (pix == PIX_LAST) begin
                  pix   <= '0;
                  state <= enable ? ST_LEAD : ST_IDLE;
               end else begin
                  pix <= pix + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end else begin
         tick <= tick + 1'b1;
      end
   end

   // R4
   tick_in_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN) |-> (tick < cfg_pix_div));

   // R9
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |=> (tick == '0));
endmodule

// File: rtl/ccd_tg_pix_wave.sv
module ccd_tg_pix_wave
   import ccd_tg_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  tg_state_e        state,
   input  logic [CNT_W-1:0] tick,
   input  logic [CNT_W-1:0] cfg_pix_div,
   input  logic [CNT_W-1:0] cfg_rs_start,
   input  logic [CNT_W-1:0] cfg_rs_width,
   input  logic [CNT_W-1:0] cfg_clp_start,
   input  logic [CNT_W-1:0] cfg_clp_width,
   output logic             p1_d,
   output logic             rs_d,
   output logic             clp_d,
   output logic             gate_d,
   output logic             ls_d,
   output logic             pv_d
);
   logic             in_run;
   logic [CNT_W-1:0] half;
   logic [CNT_W:0]   tick_x, rs_end, clp_end;

   assign in_run  = (state == ST_RUN);
   assign half    = cfg_pix_div >> 1;
   assign tick_x  = {1'b0, tick};
   assign rs_end  = {1'b0, cfg_rs_start}  + {1'b0, cfg_rs_width};
   assign clp_end = {1'b0, cfg_clp_start} + {1'b0, cfg_clp_width};

   assign p1_d   = in_run ? (tick >= half) : 1'b1;
   assign rs_d   = in_run && (tick >= cfg_rs_start)  && (tick_x < rs_end);
   assign clp_d  = in_run && (tick >= cfg_clp_start) && (tick_x < clp_end);
   assign pv_d   = in_run && (tick == cfg_pix_div - 1'b1);
   assign gate_d = (state == ST_GATE);
   assign ls_d   = gate_d && (tick == '0);
endmodule

// File: rtl/ccd_tg_out_reg.sv
module ccd_tg_out_reg #(
   parameter int N_GATE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              p1_d,
   input  logic              rs_d,
   input  logic              clp_d,
   input  logic              gate_d,
   input  logic              ls_d,
   input  logic              pv_d,
   output logic              p1_q,
   output logic              p2_q,
   output logic              rs_q,
   output logic              clp_q,
   output logic [N_GATE-1:0] gate_q,
   output logic              ls_q,
   output logic              pv_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p1_q  <= 1'b1;
         p2_q  <= 1'b0;
         rs_q  <= 1'b0;
         clp_q <= 1'b0;
         ls_q  <= 1'b0;
         pv_q  <= 1'b0;
      end else begin
         p1_q  <= p1_d;
         p2_q  <= ~p1_d;
         rs_q  <= rs_d;
         clp_q <= clp_d;
         ls_q  <= ls_d;
         pv_q  <= pv_d;
      end
   end

   for (genvar g = 0; g < N_GATE; g++) begin : g_gate
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) gate_q[g] <= 1'b0;
         else        gate_q[g] <= gate_d;
      end
   end
endmodule

// File: rtl/ccd_line_timing.sv
module ccd_line_timing
   import ccd_tg_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int LINE_PIX = 10755,
   parameter int N_GATE   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [CNT_W-1:0]  cfg_pix_div,
   input  logic [CNT_W-1:0]  cfg_rs_start,
   input  logic [CNT_W-1:0]  cfg_rs_width,
   input  logic [CNT_W-1:0]  cfg_clp_start,
   input  logic [CNT_W-1:0]  cfg_clp_width,
   input  logic [CNT_W-1:0]  cfg_lead,
   input  logic [CNT_W-1:0]  cfg_gate_width,
   input  logic [CNT_W-1:0]  cfg_guard,
   output logic              xfer_p1,
   output logic              xfer_p2,
   output logic              rst_pulse,
   output logic              clamp_pulse,
   output logic [N_GATE-1:0] gate_o,
   output logic              line_start,
   output logic              pix_valid
);
   if (CNT_W < 4)    $error("CNT_W must be at least 4");
   if (LINE_PIX < 2) $error("LINE_PIX must be at least 2");
   if (N_GATE < 1)   $error("N_GATE must be at least 1");

   tg_state_e        state;
   logic [CNT_W-1:0] tick;
   logic             p1_d, rs_d, clp_d, gate_d, ls_d, pv_d;

   ccd_tg_seq #(.CNT_W(CNT_W), .LINE_PIX(LINE_PIX)) u_seq (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .cfg_pix_div(cfg_pix_div), .cfg_lead(cfg_lead),
      .cfg_gate_width(cfg_gate_width), .cfg_guard(cfg_guard),
      .state(state), .tick(tick)
   );

   ccd_tg_pix_wave #(.CNT_W(CNT_W)) u_wave (
      .state(state), .tick(tick), .cfg_pix_div(cfg_pix_div),
      .cfg_rs_start(cfg_rs_start), .cfg_rs_width(cfg_rs_width),
      .cfg_clp_start(cfg_clp_start), .cfg_clp_width(cfg_clp_width),
      .p1_d(p1_d), .rs_d(rs_d), .clp_d(clp_d),
      .gate_d(gate_d), .ls_d(ls_d), .pv_d(pv_d)
   );

   ccd_tg_out_reg #(.N_GATE(N_GATE)) u_oreg (
      .clk(clk), .rst_n(rst_n),
      .p1_d(p1_d), .rs_d(rs_d), .clp_d(clp_d),
      .gate_d(gate_d), .ls_d(ls_d), .pv_d(pv_d),
      .p1_q(xfer_p1), .p2_q(xfer_p2), .rs_q(rst_pulse), .clp_q(clamp_pulse),
      .gate_q(gate_o), .ls_q(line_start), .pv_q(pix_valid)
   );

   // R2
   line_start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |-> (&gate_o));

   // R2
   line_start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> !line_start);

   // R3
   gate_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|gate_o) |-> (xfer_p1 && !xfer_p2 && !rst_pulse && !clamp_pulse));

   // R3
   guard_after_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_o[0]) |-> (xfer_p1 && !rst_pulse));

   // R6
   clamp_reset_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_pulse && clamp_pulse));

   // R7
   valid_outside_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> !(|gate_o));
endmodule

// File: tb/ccd_line_timing_bench.sv
module ccd_line_timing_bench;
   import ccd_tg_pkg::*;

   localparam int CW = 16;
   localparam int LP = 12;
   localparam int NG = 3;
   localparam int NCFG = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic [CW-1:0] cfg_pix_div, cfg_rs_start, cfg_rs_width, cfg_clp_start;
   logic [CW-1:0] cfg_clp_width, cfg_lead, cfg_gate_width, cfg_guard;
   logic xfer_p1, xfer_p2, rst_pulse, clamp_pulse, line_start, pix_valid;
   logic [NG-1:0] gate_o;

   int checks = 0;
   int fails = 0;
   bit done = 0;
   int tab [NCFG][8];

   always #5 clk = ~clk;

   ccd_line_timing #(.CNT_W(CW), .LINE_PIX(LP), .N_GATE(NG)) u_ccd_line_timing (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .cfg_pix_div(cfg_pix_div), .cfg_rs_start(cfg_rs_start),
      .cfg_rs_width(cfg_rs_width), .cfg_clp_start(cfg_clp_start),
      .cfg_clp_width(cfg_clp_width), .cfg_lead(cfg_lead),
      .cfg_gate_width(cfg_gate_width), .cfg_guard(cfg_guard),
      .xfer_p1(xfer_p1), .xfer_p2(xfer_p2), .rst_pulse(rst_pulse),
      .clamp_pulse(clamp_pulse), .gate_o(gate_o),
      .line_start(line_start), .pix_valid(pix_valid)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic chk_idle(input string req);
      chk(req, "xfer_p1 idle", int'(xfer_p1), 1);
      chk(req, "xfer_p2 idle", int'(xfer_p2), 0);
      chk(req, "rst_pulse idle", int'(rst_pulse), 0);
      chk(req, "clamp_pulse idle", int'(clamp_pulse), 0);
      chk(req, "gate_o idle", int'(gate_o), 0);
      chk(req, "line_start idle", int'(line_start), 0);
      chk(req, "pix_valid idle", int'(pix_valid), 0);
   endtask

   task automatic run_cfg(input int c);
      int d, rss, rsw, cs, cw, ld, gw, gd, per, n;
      int pv_cnt [2];
      d = tab[c][0]; rss = tab[c][1]; rsw = tab[c][2]; cs = tab[c][3];
      cw = tab[c][4]; ld = tab[c][5]; gw = tab[c][6]; gd = tab[c][7];
      per = gw + gd + LP * d + ld;
      cfg_pix_div = CW'(d); cfg_rs_start = CW'(rss); cfg_rs_width = CW'(rsw);
      cfg_clp_start = CW'(cs); cfg_clp_width = CW'(cw); cfg_lead = CW'(ld);
      cfg_gate_width = CW'(gw); cfg_guard = CW'(gd);
      @(negedge clk);
      chk_idle("R1");
      enable = 1'b1;
      n = 0;
      // R2: first line_start latency, counting the sampling edge
      while (n < 1000) begin
         @(posedge clk); n++;
         @(negedge clk);
         if (line_start) break;
      end
      chk("R2", "edges to first line_start", n, ld + 2);
      pv_cnt[0] = 0; pv_cnt[1] = 0;
      for (int k = 0; k < 2 * per; k++) begin
         int m, r, t;
         bit e_gate, e_ls, e_p1, e_rs, e_clp, e_pv, in_run;
         if (k > 0) begin
            @(posedge clk);
            @(negedge clk);
         end
         m = k % per;
         e_gate = (m < gw);
         e_ls = (m == 0);
         r = m - gw - gd;
         in_run = (r >= 0) && (r < LP * d);
         t = in_run ? (r % d) : 0;
         e_p1 = in_run ? (t >= d / 2) : 1'b1;
         e_rs = in_run && (t >= rss) && (t < rss + rsw);
         e_clp = in_run && (t >= cs) && (t < cs + cw);
         e_pv = in_run && (t == d - 1);
         chk("R2", "gate_o", int'(gate_o), e_gate ? (1 << NG) - 1 : 0);
         chk("R8", "line_start", int'(line_start), int'(e_ls));
         chk(in_run ? "R4" : "R3", "xfer_p1", int'(xfer_p1), int'(e_p1));
         chk("R4", "xfer_p2", int'(xfer_p2), int'(!e_p1));
         chk("R5", "rst_pulse", int'(rst_pulse), int'(e_rs));
         chk("R6", "clamp_pulse", int'(clamp_pulse), int'(e_clp));
         chk("R7", "pix_valid", int'(pix_valid), int'(e_pv));
         if (pix_valid) pv_cnt[k / per]++;
         // R9: drop enable inside the second line; that line must still complete
         if (k == per + 5) enable = 1'b0;
      end
      chk("R7", "pix_valid per line 0", pv_cnt[0], LP);
      chk("R7", "pix_valid per line 1", pv_cnt[1], LP);
      for (int k = 0; k < per + 4; k++) begin
         @(posedge clk);
         @(negedge clk);
         chk_idle("R9");
      end
   endtask

   initial begin
      tab[0] = '{4, 0, 1, 1, 1, 1, 2, 1};
      tab[1] = '{5, 1, 1, 2, 2, 2, 3, 2};
      tab[2] = '{7, 0, 2, 3, 3, 3, 4, 3};
      tab[3] = '{6, 1, 2, 3, 1, 1, 1, 1};
      tab[4] = '{DEF_PIX_DIV, DEF_RS_START, DEF_RS_WIDTH, DEF_CLP_START,
                 DEF_CLP_WIDTH, DEF_LEAD, DEF_GATE, DEF_GUARD};
      cfg_pix_div = CW'(4); cfg_rs_start = '0; cfg_rs_width = CW'(1);
      cfg_clp_start = CW'(1); cfg_clp_width = CW'(1); cfg_lead = CW'(1);
      cfg_gate_width = CW'(1); cfg_guard = CW'(1);
      repeat (3) @(negedge clk);
      chk_idle("R1");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk_idle("R1");
      for (int c = 0; c < NCFG; c++) run_cfg(c);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule